// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block turns the pins of several GPIO groups into a single interrupt request for a processor. Each pin has its own trigger setting. The trigger can be a level, a single edge or both edges, or the pin can be switched off. Every pin input passes through a two-stage synchronizer. The selected condition is detected on the synchronized value, and a detection sets a pending bit for that pin. A pending pin whose mask bit is clear takes part in one shared interrupt output.

Software reaches the block over a simple word-wide register bus. There are three register pages, for trigger type, mask and pending, with one 32-bit word per group in each page. A read-only status word names the highest-numbered active source, so a handler can service sources from the top down. Pending bits are cleared by writing 1 to them. A level-type pin keeps setting its pending bit for as long as its level holds.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, every trigger field reads 7 (detection off), the status word reads 0 and `irq` is low.
- R2: Group g has its trigger word at 0x700+4g, its mask word at 0x900+4g and its pending word at 0xA00+4g. The status word is at 0xB00. Pin n uses bits [4n+2:4n] of the trigger word and bit n of the mask and pending words. Bit 4n+3 always reads 0. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: Trigger code 3 sets pending on a rising edge of the synchronized pin. A change driven before clock edge k first shows in the pending word after edge k+2, and not after edge k+1.
- R4: Trigger code 2 sets pending on a falling edge only. Code 4 sets pending on either edge.
- R5: Trigger code 1 (level high) and code 0 (level low) set pending in every cycle that the level is present. A clear written while the level holds leaves the bit set.
- R6: Trigger codes 5, 6 and 7 never set pending, whatever the pin does.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: When a detection and a clear of the same pending bit fall in the same cycle, the bit stays set.
- R9: `irq` is high exactly when some pin has pending 1 and mask 0. A masked pin still records pending.
- R10: The status word has bit 31 = any active source, bits [15:8] = group and bits [7:0] = pin of the active source with the highest index group*PINS+pin. It reads 0 when no source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | NGROUPS*PINS | Asynchronous pin inputs, index group*PINS+pin |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Shared interrupt request |

## Verification
A detection on a pin and a software clear of the same pending bit can land in the same cycle. The bench provokes this on a pin set to both edges whose bit is already pending. It drives the opposite edge on the pin, then times the clear write so that it lands on the third clock edge after the pin change, the same edge that registers the new detection. After that edge the bit must still read 1. A second clear with no event must then bring it to 0. The same collision is also forced with level triggers, where a clear written while the level holds must leave the bit set.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NGROUPS = 2,
  parameter int PINS    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NGROUPS*PINS-1:0]  pins,
  input  logic                     bus_wr,
  input  logic [11:0]              bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     irq
);
  localparam int NB = NGROUPS * PINS;
  localparam logic [3:0] PG_CFG = 4'h7, PG_MSK = 4'h9, PG_PND = 4'hA, PG_STA = 4'hB;
  localparam logic [2:0] T_LOW = 3'd0, T_HIGH = 3'd1, T_FALL = 3'd2, T_RISE = 3'd3,
                         T_BOTH = 3'd4, T_OFF = 3'd7;

  logic [NB-1:0] s1, s2, prev, pend, mask_q, ev, clr, active;
  logic [NB-1:0][2:0] cfg;
  logic       st_valid;
  logic [7:0] st_grp, st_pin;

  wire [3:0] page    = bus_addr[11:8];
  wire [5:0] gsel    = bus_addr[7:2];
  wire       aligned = (bus_addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1 <= pins; s2 <= s1; prev <= s2;
    end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    wire hit = bus_wr && aligned && (gsel == 6'(g));
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam int I = g * PINS + p;
      assign clr[I] = hit && (page == PG_PND) && bus_wdata[p];

      always_comb
        case (cfg[I])
          T_LOW:   ev[I] = ~s2[I];
          T_HIGH:  ev[I] = s2[I];
          T_FALL:  ev[I] = prev[I] & ~s2[I];
          T_RISE:  ev[I] = ~prev[I] & s2[I];
          T_BOTH:  ev[I] = prev[I] ^ s2[I];
          default: ev[I] = 1'b0;
        endcase

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cfg[I]    <= T_OFF;
          mask_q[I] <= 1'b1;
          pend[I]   <= 1'b0;
        end else begin
          if (hit && page == PG_CFG) cfg[I] <= bus_wdata[4*p +: 3];
          if (hit && page == PG_MSK) mask_q[I] <= bus_wdata[p];
          pend[I] <= (pend[I] & ~clr[I]) | ev[I];
        end
    end
  end

  assign active = pend & ~mask_q;
  assign irq    = |active;

  always_comb begin
    st_valid = 1'b0;
    st_grp   = '0;
    st_pin   = '0;
    for (int g = 0; g < NGROUPS; g++)
      for (int p = 0; p < PINS; p++)
        if (active[g*PINS+p]) begin
          st_valid = 1'b1;
          st_grp   = 8'(g);
          st_pin   = 8'(p);
        end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int g = 0; g < NGROUPS; g++)
        if (gsel == 6'(g))
          for (int p = 0; p < PINS; p++)
            case (page)
              PG_CFG:  bus_rdata[4*p +: 3] = cfg[g*PINS+p];
              PG_MSK:  bus_rdata[p]        = mask_q[g*PINS+p];
              PG_PND:  bus_rdata[p]        = pend[g*PINS+p];
              default: ;
            endcase
      if (page == PG_STA && gsel == 6'd0)
        bus_rdata = {st_valid, 15'b0, st_grp, st_pin};
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NGROUPS = 2,
  parameter int PINS    = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         irq,
  input logic                         st_valid,
  input logic [NGROUPS*PINS-1:0]      pend,
  input logic [NGROUPS*PINS-1:0]      mask_q,
  input logic [NGROUPS*PINS-1:0]      clr,
  input logic [NGROUPS*PINS-1:0]      s2,
  input logic [NGROUPS*PINS-1:0]      prev,
  input logic [NGROUPS*PINS-1:0][2:0] cfg
);
  localparam int NB = NGROUPS * PINS;

  // R9
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (&mask_q) |-> !irq);

  // R10
  status_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) st_valid == irq);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[i]) |-> $past(clr[i]));

    // R3
    rise_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i] == 3'd3 && s2[i] && !prev[i]) |=> pend[i]);

    // R5
    level_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i] == 3'd1 && s2[i]) |=> pend[i]);

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i] >= 3'd5 && !pend[i]) |=> !pend[i]);
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NGROUPS(NGROUPS), .PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .st_valid(st_valid), .pend(pend),
  .mask_q(mask_q), .clr(clr), .s2(s2), .prev(prev), .cfg(cfg)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NG = 2, NP = 8;
  logic clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [NG*NP-1:0] pins = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_irq_ctrl #(.NGROUPS(NG), .PINS(NP)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pins(pins), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #2; d = bus_rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_type(int g, int p, logic [2:0] t);
    logic [31:0] w;
    w = (32'h77777777 & ~(32'hF << (4*p))) | (32'(t) << (4*p));
    wr(12'(12'h700 + 4*g), w);
  endtask

  task automatic cleanup();
    for (int g = 0; g < NG; g++) begin
      wr(12'(12'h700 + 4*g), 32'h77777777);
      wr(12'(12'h900 + 4*g), 32'hFF);
    end
    pins = '0;
    wait_n(4);
    for (int g = 0; g < NG; g++) wr(12'(12'hA00 + 4*g), 32'hFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h700, d); chk("R1 cfg g0", d, 32'h77777777);
    rd(12'h704, d); chk("R1 cfg g1", d, 32'h77777777);
    rd(12'h904, d); chk("R1 mask g1", d, 32'hFF);
    rd(12'hA00, d); chk("R1 pend g0", d, 0);
    rd(12'hB00, d); chk("R1 status", d, 0);
    chk("R1 irq", 32'(irq), 0);
    wr(12'h908, 32'h0); wr(12'h800, 32'h0); wr(12'h902, 32'h0);
    rd(12'h900, d); chk("R2 ignored writes g0", d, 32'hFF);
    rd(12'h904, d); chk("R2 ignored writes g1", d, 32'hFF);
    rd(12'h800, d); chk("R2 unmapped read", d, 0);
    wr(12'h700, 32'h89ABCDEF);
    rd(12'h700, d); chk("R2 nibble fields", d, 32'h01234567);
    cleanup();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_type(0, 3, 3'd3);
    wr(12'h900, 32'hF7);
    pins[3] = 1;
    wait_n(2);
    rd(12'hA00, d); chk("R3 not yet after two edges", d, 0);
    wait_n(1);
    rd(12'hA00, d); chk("R3 rise pends after three edges", d, 32'h08);
    chk("R9 irq on unmasked pend", 32'(irq), 1);
    pins[3] = 0; wait_n(4);
    rd(12'hA00, d); chk("R3 falling ignored", d, 32'h08);
    wr(12'hA00, 32'h00);
    rd(12'hA00, d); chk("R7 write 0 keeps", d, 32'h08);
    wr(12'hA00, 32'h08);
    rd(12'hA00, d); chk("R7 write 1 clears", d, 0);
    chk("R9 irq drops", 32'(irq), 0);
    cleanup();
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    set_type(1, 4, 3'd2);
    pins[12] = 1; wait_n(4);
    rd(12'hA04, d); chk("R4 fall ignores rise", d, 0);
    pins[12] = 0; wait_n(4);
    rd(12'hA04, d); chk("R4 fall pends", d, 32'h10);
    cleanup();
    set_type(1, 1, 3'd4);
    pins[9] = 1; wait_n(4);
    rd(12'hA04, d); chk("R4 both on rise", d, 32'h02);
    wr(12'hA04, 32'h02);
    pins[9] = 0; wait_n(4);
    rd(12'hA04, d); chk("R4 both on fall", d, 32'h02);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_type(0, 5, 3'd1);
    pins[5] = 1; wait_n(4);
    wr(12'hA00, 32'h20);
    rd(12'hA00, d); chk("R5 level high re-pends", d, 32'h20);
    pins[5] = 0; wait_n(4);
    wr(12'hA00, 32'h20);
    rd(12'hA00, d); chk("R5 clear after level gone", d, 0);
    cleanup();
    set_type(0, 6, 3'd0);
    wait_n(2);
    rd(12'hA00, d); chk("R5 level low pends", d, 32'h40);
    wr(12'hA00, 32'h40);
    rd(12'hA00, d); chk("R5 level low re-pends", d, 32'h40);
    pins[6] = 1; wait_n(4);
    wr(12'hA00, 32'h40);
    rd(12'hA00, d); chk("R5 level low clear when high", d, 0);
    cleanup();
  endtask

  task automatic t_off();
    logic [31:0] d;
    for (int t = 5; t < 8; t++) begin
      set_type(1, 7, 3'(t));
      pins[15] = 1; wait_n(4);
      pins[15] = 0; wait_n(4);
      rd(12'hA04, d); chk("R6 disabled code", d, 0);
    end
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    set_type(0, 1, 3'd3);
    pins[1] = 1; wait_n(4);
    rd(12'hA00, d); chk("R9 masked still pends", d, 32'h02);
    chk("R9 masked no irq", 32'(irq), 0);
    wr(12'h900, 32'hFD);
    chk("R9 unmask raises irq", 32'(irq), 1);
    cleanup();
  endtask

  task automatic t_status();
    logic [31:0] d;
    set_type(0, 2, 3'd3); set_type(1, 0, 3'd3);
    wr(12'h900, 32'hFB); wr(12'h904, 32'hFE);
    pins[2] = 1; pins[8] = 1; wait_n(4);
    rd(12'hB00, d); chk("R10 highest group wins", d, 32'h80000100);
    wr(12'h904, 32'hFF);
    rd(12'hB00, d); chk("R10 masked source skipped", d, 32'h80000002);
    wr(12'hA00, 32'h04);
    rd(12'hB00, d); chk("R10 none active", d, 0);
    cleanup();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    set_type(0, 0, 3'd4);
    pins[0] = 1; wait_n(4);
    rd(12'hA00, d); chk("R8 setup pend", d, 32'h01);
    pins[0] = 0;
    wait_n(2);
    wr(12'hA00, 32'h01);
    rd(12'hA00, d); chk("R8 event beats clear", d, 32'h01);
    wr(12'hA00, 32'h01);
    rd(12'hA00, d); chk("R8 plain clear", d, 0);
    cleanup();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    t_reset();
    t_rise();
    t_fall_both();
    t_level();
    t_off();
    t_mask();
    t_status();
    t_collide();
    finish_run();
  end
endmodule